// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Power Control

This block is the digital engine of a 12-bit successive-approximation converter. Each conversion begins with a start request. From then on the block presents a trial code to the capacitive DAC, takes the comparator's decision on that code, and moves on to the next lower bit. After the last decision it writes the coded result into a holding register. The host can read that register at any time until the next conversion finishes.

Each decision is paced by one of two sources. In serial-clock mode, an event marking a serial-clock falling edge paces the steps. In internal mode, a divider on the system clock paces them. A three-level shutdown input sets the divider ratio, and when driven low it forces hard power-down.

A mode field that arrives with the start request selects three things: serial-clock pacing, internal pacing, or internal pacing followed by automatic power-down once the conversion ends. A polarity bit selects straight binary or two's-complement output coding. After reset, the block waits out a power-on interval and then rests in internal mode with the strobe high.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset release with `shdn_lvl` not 2'b00, `busy`=0, `strobe`=1, `pwr_dn`=0, `dac_code`=0 and `result`=0.
- R2: A `start_req` during the first `POR_CYCLES` clocks after reset release is ignored: `busy` stays 0.
- R3: An accepted `start_req` sets `busy` and `dac_code` = 12'h800 on the next clock. Each later step keeps the bit under trial if `cmp_hi`=1, clears it otherwise, and sets the next lower bit. The 12 bits are resolved from MSB to LSB, so the final code is the largest code that the comparator accepts.
- R4: The polarity bit `cfg_bip` selects the output coding. With `cfg_bip`=0 the result is the final code unchanged (straight binary). With `cfg_bip`=1 the result is the final code with bit 11 inverted (two's complement).
- R5: In internal mode (`cfg_pd` of 2'b10, 2'b01 or 2'b00) a step happens every `DIV_FAST` clocks when `shdn_lvl`=2'b01 (floating) and every `DIV_SLOW` clocks when `shdn_lvl`=2'b10 (high). `busy` stays high for exactly 12 × ratio clocks, and `sclk_tick` has no effect on this.
- R6: With `cfg_pd`=2'b11 (serial-clock mode) a step happens only on a clock where `sclk_tick`=1, so exactly 12 ticks complete a conversion.
- R7: In internal mode `strobe` is low while `busy` and high otherwise. In serial-clock mode `strobe` is high from the accepted start until the first step, and low at all other times.
- R8: `result` changes only when a conversion completes. A start, a restart or an abort leaves it unchanged.
- R9: With `cfg_pd`=2'b00 the conversion completes and `result` is updated before `pwr_dn` rises. A later accepted start clears `pwr_dn`, and the block stays powered up unless that start also uses 2'b00.
- R10: With `shdn_lvl`=2'b00, `pwr_dn`=1 at once and a running conversion ends on the next clock with `busy`=0 and `dac_code`=0. Start requests are ignored while `shdn_lvl`=2'b00.
- R11: A start accepted while `busy` abandons the running conversion and restarts from the MSB with the new mode fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| start_req | input | 1 | One-cycle start request (hold instant) |
| cfg_pd | input | 2 | Clock/power mode: 11 serial clock, 10/01 internal, 00 internal then power down |
| cfg_bip | input | 1 | 1 = two's-complement output, 0 = straight binary |
| cmp_hi | input | 1 | Comparator decision: input at or above trial code |
| sclk_tick | input | 1 | One-cycle event per serial-clock falling edge |
| shdn_lvl | input | 2 | Shutdown level: 00 low, 01 floating, 10/11 high |
| dac_code | output | 12 | Trial code to the DAC |
| busy | output | 1 | Conversion in progress |
| strobe | output | 1 | Conversion strobe |
| result | output | 12 | Holding register with the last coded result |
| pwr_dn | output | 1 | Block is powered down |

## Verification
The hardest case to reach from the ports is a shutdown or restart that lands in the middle of a conversion. Only that case shows that the holding register keeps the previous result and that the sequencer starts again cleanly from the MSB. The bench sets up these cases with directed sequences. It lets a conversion run a chosen number of divider periods or serial ticks, then either pulls the shutdown level low or issues a new start with a different target value. The comparator is modelled in the bench as a compare of a target value against the presented trial code. The random conversions mix polarity, pacing source, divider ratio and stray serial ticks.

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
  parameter int N_BITS     = 12,
  parameter int DIV_FAST   = 8,
  parameter int DIV_SLOW   = 53,
  parameter int POR_CYCLES = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [1:0]        cfg_pd,
  input  logic              cfg_bip,
  input  logic              cmp_hi,
  input  logic              sclk_tick,
  input  logic [1:0]        shdn_lvl,
  output logic [N_BITS-1:0] dac_code,
  output logic              busy,
  output logic              strobe,
  output logic [N_BITS-1:0] result,
  output logic              pwr_dn
);
  localparam int BW   = $clog2(N_BITS);
  localparam int DMAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int DW   = $clog2(DMAX + 1);
  localparam int PW   = $clog2(POR_CYCLES + 1);
  localparam logic [N_BITS-1:0] MSB = {1'b1, {(N_BITS-1){1'b0}}};

  logic [PW-1:0]     por_cnt;
  logic [N_BITS-1:0] sar;
  logic [BW-1:0]     bit_q;
  logic [DW-1:0]     div_q;
  logic              ext_q, bip_q, auto_dn_q, sw_dn, first_q;

  wire hw_dn    = (shdn_lvl == 2'b00);
  wire ready    = (por_cnt == PW'(POR_CYCLES));
  wire start_ok = start_req && ready && !hw_dn;
  wire [DW-1:0] ratio = (shdn_lvl == 2'b01) ? DW'(DIV_FAST) : DW'(DIV_SLOW);
  wire tick     = ext_q ? sclk_tick : (div_q >= ratio - DW'(1));
  wire last     = (bit_q == '0);
  wire [N_BITS-1:0] cur_bit = {{(N_BITS-1){1'b0}}, 1'b1} << bit_q;
  wire [N_BITS-1:0] decided = cmp_hi ? sar : (sar & ~cur_bit);
  wire [N_BITS-1:0] nxt_sar = decided | (cur_bit >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_cnt   <= '0;
      sar       <= '0;
      bit_q     <= '0;
      div_q     <= '0;
      ext_q     <= 1'b0;
      bip_q     <= 1'b0;
      auto_dn_q <= 1'b0;
      sw_dn     <= 1'b0;
      first_q   <= 1'b0;
      busy      <= 1'b0;
      result    <= '0;
    end else begin
      if (!ready) por_cnt <= por_cnt + PW'(1);
      if (hw_dn) begin
        busy    <= 1'b0;
        sar     <= '0;
        first_q <= 1'b0;
      end else if (start_ok) begin
        busy      <= 1'b1;
        sar       <= MSB;
        bit_q     <= BW'(N_BITS-1);
        div_q     <= '0;
        ext_q     <= (cfg_pd == 2'b11);
        bip_q     <= cfg_bip;
        auto_dn_q <= (cfg_pd == 2'b00);
        sw_dn     <= 1'b0;
        first_q   <= 1'b1;
      end else if (busy) begin
        if (!ext_q) div_q <= tick ? '0 : div_q + DW'(1);
        if (tick) begin
          first_q <= 1'b0;
          if (last) begin
            busy   <= 1'b0;
            sar    <= '0;
            result <= {decided[N_BITS-1] ^ bip_q, decided[N_BITS-2:0]};
            sw_dn  <= auto_dn_q;
          end else begin
            sar   <= nxt_sar;
            bit_q <= bit_q - BW'(1);
          end
        end
      end
    end
  end

  assign dac_code = sar;
  assign strobe   = ext_q ? (busy & first_q) : ~busy;
  assign pwr_dn   = hw_dn | sw_dn;

  // R10
  hw_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_dn |=> (!busy && dac_code == '0));
  // R3
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (busy && dac_code == MSB));
  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(busy));
  // R9
  sw_dn_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_dn) |-> $fell(busy));
  // R6
  ext_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ext_q && !sclk_tick && !start_req && !hw_dn) |=> $stable(dac_code));
endmodule

// File: tb/sim_sar_seq_ctrl.sv
module sim_sar_seq_ctrl;
  localparam int DF = 8, DS = 53, POR = 120;
  logic clk = 1'b0, rst_n = 1'b0, start_req = 1'b0, cfg_bip = 1'b0, sclk_tick = 1'b0;
  logic [1:0] cfg_pd = 2'b10, shdn_lvl = 2'b01;
  logic [11:0] vin = '0;
  logic [11:0] dac_code, result;
  logic busy, strobe, pwr_dn, cmp_hi;
  int checks = 0, fails = 0, cyc = 0;

  assign cmp_hi = (vin >= dac_code);
  always #2.5 clk = ~clk;

  sar_seq_ctrl #(.N_BITS(12), .DIV_FAST(DF), .DIV_SLOW(DS), .POR_CYCLES(POR)) u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .cfg_pd(cfg_pd), .cfg_bip(cfg_bip),
    .cmp_hi(cmp_hi), .sclk_tick(sclk_tick), .shdn_lvl(shdn_lvl), .dac_code(dac_code),
    .busy(busy), .strobe(strobe), .result(result), .pwr_dn(pwr_dn));

  function automatic logic [11:0] coded(logic [11:0] v, logic bip);
    return bip ? {~v[11], v[10:0]} : v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic kick(logic [11:0] v, logic bip, logic [1:0] pd);
    @(negedge clk);
    vin = v; cfg_bip = bip; cfg_pd = pd; start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic run_int(logic [11:0] v, logic bip, logic [1:0] pd, logic [1:0] sh);
    int n = 1;
    int r = (sh == 2'b01) ? DF : DS;
    logic [11:0] prev;
    shdn_lvl = sh;
    kick(v, bip, pd);
    chk(busy && dac_code == 12'h800, "R3 msb trial", dac_code, 12'h800);
    chk(!strobe && !pwr_dn, "R7 int strobe low while busy / R9 woken", {strobe, pwr_dn}, 0);
    prev = dac_code;
    forever begin
      @(negedge clk);
      sclk_tick = 1'($urandom);
      if (!busy) break;
      n++;
    end
    sclk_tick = 1'b0;
    chk(n == 12 * r, "R5 busy length", n, 12 * r);
    chk(result == coded(v, bip), "R4 result coding", result, coded(v, bip));
    chk(strobe == 1'b1, "R7 int strobe idle", strobe, 1);
    chk(pwr_dn == (pd == 2'b00), "R9 power state after done", pwr_dn, pd == 2'b00);
  endtask

  task automatic run_ext(logic [11:0] v, logic bip);
    int t = 0;
    kick(v, bip, 2'b11);
    chk(strobe == 1'b1, "R7 ext strobe before first step", strobe, 1);
    while (busy && t < 40) begin
      sclk_tick = 1'b1;
      @(negedge clk);
      sclk_tick = 1'b0;
      t++;
      if (busy) chk(strobe == 1'b0, "R7 ext strobe after first step", strobe, 0);
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    chk(t == 12, "R6 tick count", t, 12);
    chk(result == coded(v, bip), "R3 R4 ext result", result, coded(v, bip));
    chk(!strobe && !pwr_dn, "R7 ext idle strobe low", {strobe, pwr_dn}, 0);
  endtask

  initial begin
    logic [11:0] held;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && strobe && !pwr_dn && dac_code == 0 && result == 0, "R1 reset state",
        {busy, strobe, pwr_dn}, 3'b010);
    repeat (10) @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk(!busy, "R2 start ignored in power-on window", busy, 0);
    repeat (POR) @(negedge clk);

    run_int(12'hFFF, 1'b0, 2'b10, 2'b01);
    run_int(12'h000, 1'b0, 2'b10, 2'b10);
    run_int(12'h800, 1'b1, 2'b01, 2'b01);
    run_ext(12'h7FF, 1'b1);
    run_int(12'h3A5, 1'b0, 2'b00, 2'b01);
    chk(result == 12'h3A5, "R9 result readable while powered down", result, 12'h3A5);
    run_int(12'h5C3, 1'b1, 2'b10, 2'b01);
    chk(!pwr_dn, "R9 stays up after 1x start", pwr_dn, 0);

    // R10 abort mid conversion
    held = result;
    shdn_lvl = 2'b01;
    kick(12'h9AB, 1'b0, 2'b10);
    repeat (5 * DF) @(negedge clk);
    shdn_lvl = 2'b00;
    #0.5;
    chk(pwr_dn, "R10 pwr_dn immediate", pwr_dn, 1);
    @(negedge clk);
    chk(!busy && dac_code == 0, "R10 abort", {busy, dac_code}, 0);
    chk(result == held, "R8 result kept on abort", result, held);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk(!busy, "R10 start ignored in shutdown", busy, 0);
    shdn_lvl = 2'b01;
    @(negedge clk);
    chk(!pwr_dn && !busy, "R10 release", {pwr_dn, busy}, 0);

    // R11 restart
    held = result;
    kick(12'h123, 1'b0, 2'b11);
    repeat (4) begin
      sclk_tick = 1'b1; @(negedge clk); sclk_tick = 1'b0;
    end
    chk(result == held, "R8 result kept on restart", result, held);
    run_int(12'hE4D, 1'b0, 2'b10, 2'b01);
    chk(result == 12'hE4D, "R11 restart result", result, 12'hE4D);

    for (int i = 0; i < 24; i++) begin
      logic [11:0] v = 12'($urandom);
      logic b = 1'($urandom);
      int m = $urandom_range(0, 3);
      if (m == 3) run_ext(v, b);
      else run_int(v, b, (m == 0) ? 2'b00 : (m == 1 ? 2'b10 : 2'b01),
                   1'($urandom) ? 2'b01 : 2'b10);
    end
    finish_run();
  end
endmodule